// File: doc/BRIEF.md
# Four-Channel Buffered Pulse Width Modulator

This block produces four independent pulse width modulated outputs under the control of a small memory-mapped register file. Each channel divides the input clock by a selectable power of two, counts prescaled ticks from zero up to its period, and compares the count against a threshold. The threshold gives the number of inactive ticks at the start of each period. The channel is active for the rest of the period. A polarity bit inverts the pin.

Software starts and stops channels by writing one-hot masks to two global registers. It can change duty and period without glitches through update registers. Those values are held and only copied into the live values when the current period ends. A stop request also takes effect only at a period end, and the status register shows the channel as running until then. A per-channel end-of-period flag is set at every period end. Reading the flag register clears all flags.

Top module: `pwm_quad`

## Requirements
- R1: A write to 0x004 starts every channel whose bit in wdata[3:0] is 1. A write to 0x008 requests a stop for the same bit pattern. Zero bits change nothing. Reading 0x00C returns the running channels in rdata[3:0].
- R2: After a stop request, a channel keeps running and its status bit stays 1 until its current period ends. It then reads 0 in status, its counter is held at zero, and its pin is at the inactive level (0 for normal polarity, 1 for inverted).
- R3: Bit n of the flag register at 0x01C is set when channel n ends a period. A read of 0x01C returns the flags and clears them in the same access. A flag raised in the cycle of that read survives the clear.
- R4: Channel n's registers sit at 0x200 + 0x20·n: mode at +0x00, duty at +0x04, duty update at +0x08, period at +0x0C and period update at +0x10. Mode bits [3:0] select a clock divide of 2^s for s from 0 to 10. Values 11 to 15 divide by 2^10.
- R5: With period P and duty D, the output is active for P−D prescaled ticks of every P. D=0 gives a fully active output. D≥P gives a fully inactive output.
- R6: Mode bit 9 set inverts the pin, so the active level is 0 and the inactive level is 1.
- R7: Writes to the duty-update or period-update register are held, and they read back from that register. They are copied into the live duty or period only at the next period end of a running channel.
- R8: A write to the duty or period register loads the live value immediately while the channel is stopped. It is ignored while the channel is running.
- R9: Only bits [15:0] of the duty and period registers are stored, and every read returns zero in rdata[31:16]. The mode register reads back with the select in bits [3:0] and the polarity in bit 9.
- R10: Starting a stopped channel clears its counter and its prescaler phase. The first prescaled tick then lasts a full 2^s clocks, beginning at count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read of 0x01C clears the flags |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| pwm_out | output | 4 | Channel outputs |

## Verification
A counter or prescaler that drifts from its proper phase shows at once on the pins as a wrong number of active cycles in a period. The sweeps count these cycles over whole periods for every small duty and period pair and for every divide setting. If update values are committed early or late, the live duty and period readback goes wrong within one period of the update write. The measured active count then goes wrong over the next full period. A stop that completes early or late shows in the status register and on the pin, both of which are read in the same period as the stop request.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int CH = 4,
  parameter int DW = 16,
  parameter int PSMAX = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  pwm_out
);
  localparam int PW = PSMAX;

  logic [DW-1:0] duty_v [CH];
  logic [DW-1:0] dsh_v  [CH];
  logic [DW-1:0] per_v  [CH];
  logic [DW-1:0] psh_v  [CH];
  logic [DW-1:0] cnt_v  [CH];
  logic [3:0]    psel_v [CH];
  logic [CH-1:0] pol_v, run_v, endp_v, isr_q;

  wire en_wr    = wr_en && addr == 12'h004;
  wire dis_wr   = wr_en && addr == 12'h008;
  wire isr_rd   = rd_en && addr == 12'h01C;
  wire bank_hit = addr[11:7] == 5'b00100;
  wire [1:0] bch  = addr[6:5];
  wire [4:0] boff = addr[4:0];

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic run, stop, dpend, ppend, pol;
    logic [3:0] psel;
    logic [DW-1:0] duty, dsh, per, psh, cnt;
    logic [PW-1:0] pre;

    wire hit    = wr_en && bank_hit && bch == 2'(i);
    wire w_mode = hit && boff == 5'h00;
    wire w_duty = hit && boff == 5'h04;
    wire w_dsh  = hit && boff == 5'h08;
    wire w_per  = hit && boff == 5'h0C;
    wire w_psh  = hit && boff == 5'h10;

    wire [3:0]    sel  = (psel > 4'(PSMAX)) ? 4'(PSMAX) : psel;
    wire [PW:0]   mask = (PW+1)'(((PW+1)'(1) << sel) - (PW+1)'(1));
    wire          tick = run && pre == mask[PW-1:0];
    wire          endp = tick && ({1'b0, cnt} + (DW+1)'(1) >= {1'b0, per});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= 1'b0; stop <= 1'b0; dpend <= 1'b0; ppend <= 1'b0; pol <= 1'b0;
        psel <= '0; duty <= '0; dsh <= '0; per <= '0; psh <= '0;
        cnt <= '0; pre <= '0;
      end else begin
        if (w_mode) begin
          psel <= wdata[3:0];
          pol  <= wdata[9];
        end
        if (run) begin
          pre <= tick ? '0 : pre + PW'(1);
          if (tick) cnt <= endp ? '0 : cnt + DW'(1);
        end
        if (endp) begin
          if (dpend) begin duty <= dsh; dpend <= 1'b0; end
          if (ppend) begin per <= psh; ppend <= 1'b0; end
          if (stop)  begin run <= 1'b0; stop <= 1'b0; end
        end
        if (w_duty && !run) duty <= wdata[DW-1:0];
        if (w_per && !run)  per  <= wdata[DW-1:0];
        if (w_dsh) begin dsh <= wdata[DW-1:0]; dpend <= 1'b1; end
        if (w_psh) begin psh <= wdata[DW-1:0]; ppend <= 1'b1; end
        if (en_wr && wdata[i]) begin
          run  <= 1'b1;
          stop <= 1'b0;
          if (!run) begin cnt <= '0; pre <= '0; end
        end else if (dis_wr && wdata[i] && run) begin
          stop <= 1'b1;
        end
      end
    end

    assign pwm_out[i] = (run && cnt >= duty) ^ pol;
    assign duty_v[i] = duty;
    assign dsh_v[i]  = dsh;
    assign per_v[i]  = per;
    assign psh_v[i]  = psh;
    assign cnt_v[i]  = cnt;
    assign psel_v[i] = psel;
    assign pol_v[i]  = pol;
    assign run_v[i]  = run;
    assign endp_v[i] = endp;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_rd ? '0 : isr_q) | endp_v;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == 12'h00C) rdata[CH-1:0] = run_v;
      else if (addr == 12'h01C) rdata[CH-1:0] = isr_q;
      else if (bank_hit) begin
        case (boff)
          5'h00: begin rdata[3:0] = psel_v[bch]; rdata[9] = pol_v[bch]; end
          5'h04: rdata[DW-1:0] = duty_v[bch];
          5'h08: rdata[DW-1:0] = dsh_v[bch];
          5'h0C: rdata[DW-1:0] = per_v[bch];
          5'h10: rdata[DW-1:0] = psh_v[bch];
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

module pwm_quad_chk #(
  parameter int CH = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [11:0]   addr,
  input logic [31:0]   rdata,
  input logic [3:0]    pwm_out,
  input logic [CH-1:0] run_v,
  input logic [CH-1:0] endp_v,
  input logic [CH-1:0] isr_q,
  input logic [CH-1:0] pol_v,
  input logic [DW-1:0] cnt_v [CH],
  input logic [DW-1:0] per_v [CH]
);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rdata[31:16] == 16'h0);

  a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 12'h01C) |=> isr_q == $past(endp_v));

  for (genvar i = 0; i < CH; i++) begin : g_a
    a_r2_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_v[i]) |-> $past(endp_v[i]));
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[i] |-> (pwm_out[i] == pol_v[i] && cnt_v[i] == '0));
    a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_v[i]) |-> cnt_v[i] == '0);
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[i] && per_v[i] != '0) |-> cnt_v[i] < per_v[i]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.CH(CH), .DW(DW)) u_chk (.*);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [11:0] A_EN = 12'h004, A_DIS = 12'h008, A_ST = 12'h00C, A_ISR = 12'h01C;

  always #2 clk = ~clk;

  pwm_quad u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
               .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  function automatic logic [11:0] rg(input int ch, input int off);
    return 12'(32'h200 + ch * 32'h20 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); if (pwm_out[ch]) h++; end
  endtask

  task automatic stop_ch(input int ch);
    logic [31:0] d;
    wr(A_DIS, 32'(1) << ch);
    for (int k = 0; k < 6000; k++) begin
      rd(A_ST, d);
      if (!d[ch]) break;
    end
  endtask

  task automatic run_cfg(input int ch, input int s, input int pol, input int p, input int dty, input string req);
    int h, win, act, es;
    stop_ch(ch);
    wr(rg(ch, 0), 32'(s) | (32'(pol) << 9));
    wr(rg(ch, 4), 32'(dty));
    wr(rg(ch, 12), 32'(p));
    wr(A_EN, 32'(1) << ch);
    es = (s > 10) ? 10 : s;
    win = 2 * p * (1 << es);
    act = (dty >= p) ? 0 : 2 * (p - dty) * (1 << es);
    highs(ch, win, h);
    check(req, 32'(h), 32'(pol ? win - act : act));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_ST, d);  check("R1 reset status", d, 0);
    rd(A_ISR, d); check("R3 reset flags", d, 0);
    check("R2 reset pins", 32'(pwm_out), 0);

    // R5 sweep of duty/period, both polarities (R6)
    for (int p = 1; p <= 6; p++)
      for (int dd = 0; dd <= p + 1; dd++)
        for (int pl = 0; pl < 2; pl++)
          run_cfg(0, 0, pl, p, dd, pl ? "R6 inverted sweep" : "R5 duty sweep");

    // R4 prescaler sweep including clamped selects
    for (int s = 0; s <= 11; s++) run_cfg(1, s, 0, 3, 1, "R4 divide");
    run_cfg(1, 15, 0, 3, 1, "R4 clamp 15");

    // R10 phase after start: s=1, P=4, D=2
    stop_ch(2);
    wr(rg(2, 0), 1); wr(rg(2, 4), 2); wr(rg(2, 12), 4);
    wr(A_EN, 4);
    for (int k = 0; k < 8; k++) begin
      check("R10 start phase", 32'(pwm_out[2]), 32'((k / 2) >= 2));
      @(negedge clk);
    end

    // R3 flags: long period
    stop_ch(3);
    wr(rg(3, 0), 0); wr(rg(3, 4), 500); wr(rg(3, 12), 1000);
    rd(A_ISR, d);
    wr(A_EN, 8);
    repeat (1010) @(negedge clk);
    rd(A_ISR, d); check("R3 flag set", 32'(d[3]), 1);
    rd(A_ISR, d); check("R3 flag cleared", 32'(d[3]), 0);

    // R2 delayed stop on channel 3 (period 1000, now mid-period)
    wr(A_DIS, 8);
    rd(A_ST, d); check("R2 status held", 32'(d[3]), 1);
    repeat (1000) @(negedge clk);
    rd(A_ST, d); check("R2 status clear", 32'(d[3]), 0);
    check("R2 idle level", 32'(pwm_out[3]), 0);
    wr(rg(3, 0), 32'h200);
    @(negedge clk);
    check("R2 idle level inverted", 32'(pwm_out[3]), 1);

    // R7 / R8 on channel 0: P=40 D=10
    stop_ch(0);
    wr(rg(0, 0), 0); wr(rg(0, 4), 10); wr(rg(0, 12), 40);
    wr(A_EN, 1);
    repeat (80) @(negedge clk);
    wr(rg(0, 8), 30);
    rd(rg(0, 4), d); check("R7 duty not yet live", d, 10);
    rd(rg(0, 8), d); check("R7 held duty readback", d, 30);
    wr(rg(0, 4), 5);
    rd(rg(0, 4), d); check("R8 direct write ignored while running", d, 10);
    repeat (50) @(negedge clk);
    rd(rg(0, 4), d); check("R7 duty committed", d, 30);
    highs(0, 80, h); check("R7 committed duty output", 32'(h), 20);
    wr(rg(0, 16), 50);
    rd(rg(0, 12), d); check("R7 period not yet live", d, 40);
    repeat (60) @(negedge clk);
    rd(rg(0, 12), d); check("R7 period committed", d, 50);
    highs(0, 100, h); check("R7 committed period output", 32'(h), 40);

    // R9 width and mode readback
    stop_ch(0);
    wr(rg(0, 12), 32'hABCD_1234);
    rd(rg(0, 12), d); check("R9 period low half", d, 32'h1234);
    wr(rg(0, 4), 32'hFFFF_0007);
    rd(rg(0, 4), d); check("R8 R9 direct duty while stopped", d, 32'h0007);
    wr(rg(0, 0), 32'hFFFF_FFFF);
    rd(rg(0, 0), d); check("R9 mode readback", d, 32'h20F);

    // R1 all four channels together
    for (int c = 0; c < 4; c++) begin
      stop_ch(c);
      wr(rg(c, 0), 0);
    end
    wr(rg(0, 12), 4);  wr(rg(0, 4), 1);
    wr(rg(1, 12), 5);  wr(rg(1, 4), 2);
    wr(rg(2, 12), 8);  wr(rg(2, 4), 0);
    wr(rg(3, 12), 10); wr(rg(3, 4), 7);
    wr(A_EN, 32'hF);
    rd(A_ST, d); check("R1 all running", d, 32'hF);
    begin
      int hc[4];
      hc = '{0, 0, 0, 0};
      repeat (40) begin
        @(negedge clk);
        for (int c = 0; c < 4; c++) if (pwm_out[c]) hc[c]++;
      end
      check("R1 ch0 output", 32'(hc[0]), 30);
      check("R1 ch1 output", 32'(hc[1]), 24);
      check("R1 ch2 output", 32'(hc[2]), 40);
      check("R1 ch3 output", 32'(hc[3]), 12);
    end
    wr(A_DIS, 32'h5);
    repeat (20) @(negedge clk);
    rd(A_ST, d); check("R1 partial stop", d, 32'hA);
    wr(A_EN, 0);
    rd(A_ST, d); check("R1 zero enable bits", d, 32'hA);
    wr(A_DIS, 0);
    repeat (20) @(negedge clk);
    rd(A_ST, d); check("R1 zero disable bits", d, 32'hA);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule